// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register Block

This block holds the byte-wide control registers of a two-channel disk bus-master DMA engine and combines the two channel interrupts into one output line. Software reaches the registers through a synchronous byte port. The low half of the 16-byte space belongs to channel 0 and the high half belongs to channel 1. Each half holds the following registers:
- a command byte;
- a mode byte, which both channels share;
- a status byte;
- a timing byte for that channel;
- a 32-bit descriptor table pointer.

The DMA engine and the drives feed per-channel inputs: interrupt levels, error and interrupt events, and DMA-active set and clear strobes. The shared mode byte captures the interrupt levels as pending flags. It also holds one software block flag per channel. A pending flag whose block flag is clear drives the combined interrupt.

Writes take effect at the rising clock edge. Reads are combinational from the addressed register.

Top module: `idebm_regfile`

## Requirements
- R1: After reset, all registers of both channels read 0, including the shared mode byte, and `irq_out` is low.
- R2: `bus_addr[3]` selects the channel, and `bus_addr[2:0]` selects the register inside the window. Offset 0 is a per-channel command byte that reads back its last written value.
- R3: The mode byte reads the same at offset 1 and offset 9. A write to either offset changes only bit 4 (block channel 0) and bit 5 (block channel 1).
- R4: Mode bit 2 takes the level of `irq_in[0]`, and mode bit 3 takes the level of `irq_in[1]`, one clock edge after the input is sampled.
- R5: `irq_out` is high exactly when (mode bit 2 is set and bit 4 is clear) or (mode bit 3 is set and bit 5 is clear). It follows the mode byte in the same cycle.
- R6: A status write (offset 2) stores bits 5 and 6 and leaves bit 0 unchanged. Bits 3, 4 and 7 always read 0.
- R7: Status bit 1 (error) and bit 2 (interrupt) are set by `err_evt` and `int_evt`. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write wins.
- R8: Status bit 0 (DMA active) is set by `dma_set` and cleared by `dma_clr`. When both are high, set wins.
- R9: Offset 3 is a timing byte with separate storage for each channel.
- R10: Offsets 4 to 7 hold the descriptor pointer as little-endian bytes (offset 4 is bits 7:0). Bits 1:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_in | input | 2 | Channel interrupt levels |
| err_evt | input | 2 | Per-channel error event (sets status bit 1) |
| int_evt | input | 2 | Per-channel interrupt event (sets status bit 2) |
| dma_set | input | 2 | Per-channel DMA-active set |
| dma_clr | input | 2 | Per-channel DMA-active clear |
| irq_out | output | 1 | Combined interrupt |

## Verification
A register write or a hardware strobe applied before a rising edge is visible on `bus_rdata` after that edge. A level on `irq_in` reaches the mode byte, and through it `irq_out`, after the same single edge. `irq_out` carries no further register stage.

The bench changes inputs on the falling edge, lets one rising edge pass, and samples shortly after the following falling edge. Every check therefore lands exactly one register stage after its stimulus. Same-cycle conflicts are driven within one cycle so that priority is observed directly: event against clearing write, and set against clear.

// File: rtl/idebm_pkg.sv
package idebm_pkg;
    localparam int NCH   = 2;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int OFFW  = AW - 1;
    localparam int PTRW  = 32;
    localparam int PTRB  = PTRW / DW;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TIME = 2'd3
    } sel_e;

    typedef struct packed {
        logic       rsv7;
        logic [1:0] user;
        logic [1:0] rsv;
        logic       intr;
        logic       err;
        logic       active;
    } stat_t;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic [1:0] blk;
        logic [1:0] pend;
        logic [1:0] rsv_lo;
    } mode_t;

    function automatic logic is_ptr(input logic [OFFW-1:0] off);
        return off[OFFW-1];
    endfunction

    function automatic sel_e reg_sel(input logic [OFFW-1:0] off);
        return sel_e'(off[1:0]);
    endfunction
endpackage

// File: rtl/idebm_mode.sv
module idebm_mode
    import idebm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_we,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] irq_in,
    output mode_t          mode,
    output logic           irq_out
);
    mode_t wd;
    assign wd = mode_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else begin
            mode.pend <= irq_in;
            if (mode_we) mode.blk <= wd.blk;
        end
    end

    assign irq_out = |(mode.pend & ~mode.blk);

    // R3
    blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode.blk));

    // R4
    pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (mode.pend == $past(irq_in)));
endmodule

// File: rtl/idebm_chan.sv
module idebm_chan
    import idebm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [OFFW-1:0] off,
    input  logic [DW-1:0]   wdata,
    input  logic            err_evt,
    input  logic            int_evt,
    input  logic            dma_set,
    input  logic            dma_clr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0]   cmd_q;
    logic [DW-1:0]   time_q;
    stat_t           stat_q;
    logic [PTRW-1:0] ptr_q;

    logic wr_cmd, wr_stat, wr_time;
    stat_t wd;
    assign wd      = stat_t'(wdata);
    assign wr_cmd  = we && !is_ptr(off) && reg_sel(off) == SEL_CMD;
    assign wr_stat = we && !is_ptr(off) && reg_sel(off) == SEL_STAT;
    assign wr_time = we && !is_ptr(off) && reg_sel(off) == SEL_TIME;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            time_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_time) time_q <= wdata;
            if (dma_set)      stat_q.active <= 1'b1;
            else if (dma_clr) stat_q.active <= 1'b0;
            stat_q.err  <= err_evt | (stat_q.err  & ~(wr_stat & wd.err));
            stat_q.intr <= int_evt | (stat_q.intr & ~(wr_stat & wd.intr));
            if (wr_stat) stat_q.user <= wd.user;
            stat_q.rsv  <= '0;
            stat_q.rsv7 <= 1'b0;
        end
    end

    for (genvar b = 0; b < PTRB; b++) begin : g_ptr
        localparam int LO = (b == 0) ? 2 : 0;
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[b*DW +: DW] <= '0;
            end else if (we && is_ptr(off) && off[1:0] == b[1:0]) begin
                ptr_q[b*DW +: DW] <= wdata & ~DW'((1 << LO) - 1);
            end
        end
    end

    always_comb begin
        if (is_ptr(off)) begin
            rdata = ptr_q[off[1:0]*DW +: DW];
        end else begin
            case (reg_sel(off))
                SEL_CMD:  rdata = cmd_q;
                SEL_STAT: rdata = stat_q;
                SEL_TIME: rdata = time_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> stat_q.err);

    // R8
    dma_set_chk: assert property (@(posedge clk) disable iff (rst)
        dma_set |=> stat_q.active);

    // R10
    ptr_low_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ptr(off) && off[1:0] == 2'd0) |-> (rdata[1:0] == 2'b00));
endmodule

// File: rtl/idebm_regfile.sv
module idebm_regfile
    import idebm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] irq_in,
    input  logic [NCH-1:0] err_evt,
    input  logic [NCH-1:0] int_evt,
    input  logic [NCH-1:0] dma_set,
    input  logic [NCH-1:0] dma_clr,
    output logic           irq_out
);
    logic [OFFW-1:0] off;
    logic            ch;
    logic            mode_hit;
    logic [DW-1:0]   ch_rd [NCH];
    mode_t           mode;

    assign off      = bus_addr[OFFW-1:0];
    assign ch       = bus_addr[AW-1];
    assign mode_hit = !is_ptr(off) && reg_sel(off) == SEL_MODE;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        idebm_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .we      (bus_we && ch == c[0]),
            .off     (off),
            .wdata   (bus_wdata),
            .err_evt (err_evt[c]),
            .int_evt (int_evt[c]),
            .dma_set (dma_set[c]),
            .dma_clr (dma_clr[c]),
            .rdata   (ch_rd[c])
        );
    end

    idebm_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .mode_we (bus_we && mode_hit),
        .wdata   (bus_wdata),
        .irq_in  (irq_in),
        .mode    (mode),
        .irq_out (irq_out)
    );

    assign bus_rdata = mode_hit ? DW'(mode) : ch_rd[ch];

    // R1
    rst_irq_chk: assert property (@(posedge clk)
        $past(rst) |-> !irq_out);
endmodule

// File: tb/test_idebm_regfile.sv
module test_idebm_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 24;
    // vector: {we, addr[3:0], data[7:0]}; for reads data is the expected value
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'h0, 8'hA5}, {1'b0, 4'h0, 8'hA5},   // R2 cmd ch0
        {1'b1, 4'h8, 8'h3C}, {1'b0, 4'h8, 8'h3C},   // R2 cmd ch1
        {1'b0, 4'h0, 8'hA5},                          // R2 ch0 kept
        {1'b1, 4'h3, 8'h11}, {1'b1, 4'hB, 8'h22},   // R9
        {1'b0, 4'h3, 8'h11}, {1'b0, 4'hB, 8'h22},   // R9
        {1'b1, 4'h1, 8'hFF}, {1'b0, 4'h1, 8'h30},   // R3 only block bits
        {1'b0, 4'h9, 8'h30},                          // R3 shared
        {1'b1, 4'h2, 8'hFF}, {1'b0, 4'h2, 8'h60},   // R6
        {1'b1, 4'hA, 8'h20}, {1'b0, 4'hA, 8'h20},   // R6 ch1
        {1'b0, 4'h2, 8'h60},                          // R6 ch0 kept
        {1'b1, 4'h4, 8'h13}, {1'b1, 4'h5, 8'h57},   // R10
        {1'b1, 4'h7, 8'hDF}, {1'b0, 4'h4, 8'h10},   // R10 low bits zero
        {1'b0, 4'h5, 8'h57}, {1'b0, 4'h7, 8'hDF},   // R10
        {1'b1, 4'h9, 8'h10}                           // R3 write via ch1 window
    };

    logic       clk = 0;
    logic       rst = 1;
    logic [3:0] bus_addr = 0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [1:0] irq_in = 0, err_evt = 0, int_evt = 0, dma_set = 0, dma_clr = 0;
    logic       irq_out;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idebm_regfile i_idebm_regfile (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tick;
        @(negedge clk);
        err_evt = 0; int_evt = 0; dma_set = 0; dma_clr = 0; bus_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        for (int a = 0; a < 16; a++) rd("R1", a[3:0], 8'h00);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) wr(VEC[i][11:8], VEC[i][7:0]);
            else rd($sformatf("R2/R3/R6/R9/R10 vec%0d", i), VEC[i][11:8], VEC[i][7:0]);
        end

        // R4 / R5: mode now 0x10 (channel 0 blocked)
        @(negedge clk); irq_in = 2'b01;
        rd("R4 pend0", 4'h1, 8'h14);
        chk("R5 blocked", {7'b0, irq_out}, 8'h00);
        irq_in = 2'b10;
        rd("R4 pend1", 4'h9, 8'h18);
        chk("R5 ch1", {7'b0, irq_out}, 8'h01);
        wr(4'h1, 8'h30);
        #1 chk("R5 both blocked", {7'b0, irq_out}, 8'h00);
        rd("R4 mode", 4'h1, 8'h38);
        wr(4'h9, 8'h00);
        #1 chk("R5 unblocked", {7'b0, irq_out}, 8'h01);
        irq_in = 2'b00;
        rd("R4 drop", 4'h1, 8'h00);
        chk("R5 low", {7'b0, irq_out}, 8'h00);

        // R7 on channel 0 (status currently 0x60)
        @(negedge clk); err_evt = 2'b01;
        tick; rd("R7 err set", 4'h2, 8'h62);
        @(negedge clk); int_evt = 2'b01;
        tick; rd("R7 int set", 4'h2, 8'h66);
        wr(4'h2, 8'h02);
        rd("R7 w1c err", 4'h2, 8'h04);
        @(negedge clk); bus_addr = 4'h2; bus_we = 1; bus_wdata = 8'h04; int_evt = 2'b01;
        tick; rd("R7 event wins", 4'h2, 8'h04);
        wr(4'h2, 8'h00);
        rd("R7 write 0 keeps", 4'h2, 8'h04);
        wr(4'h2, 8'h04);
        rd("R7 w1c int", 4'h2, 8'h00);
        rd("R7 ch1 untouched", 4'hA, 8'h20);

        // R8 on channel 1
        @(negedge clk); dma_set = 2'b10;
        tick; rd("R8 set", 4'hA, 8'h21);
        wr(4'hA, 8'h00);
        rd("R6 bit0 kept", 4'hA, 8'h01);
        @(negedge clk); dma_clr = 2'b10;
        tick; rd("R8 clr", 4'hA, 8'h00);
        @(negedge clk); dma_set = 2'b10; dma_clr = 2'b10;
        tick; rd("R8 set wins", 4'hA, 8'h01);
        rd("R8 ch0 untouched", 4'h2, 8'h00);

        // R1 reset mid-run
        @(negedge clk); irq_in = 2'b01; rst = 1;
        @(negedge clk); rst = 0; irq_in = 2'b00;
        #1 chk("R1 irq after reset", {7'b0, irq_out}, 8'h00);
        rd("R1 cmd", 4'h0, 8'h00);
        rd("R1 status", 4'hA, 8'h00);
        rd("R1 timing", 4'hB, 8'h00);
        rd("R1 ptr", 4'h7, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule